// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt a hardware thread should take next. It holds a register of pending interrupt lines and a register of claimed lines. Interrupt sources update the pending register through masked writes. Each cycle the block combines the pending lines with the per-line enables, the delegation mask, the current privilege level and the two global enable bits. It registers a take flag and the cause index of the winning line.

The pending register also drives a request line to the hart. That line is refreshed on every pending write. Each write returns the previous contents of the register. The claim register lets a hardware agent take ownership of a set of lines. A claim fails if any of the requested lines already has an owner.

Top module: `irq_select_top`

## Requirements
- R1: A line is a candidate only when its pending bit and its enable bit are both 1. A line that is pending but disabled is never selected.
- R2: Lines whose delegation bit is 0 are gated by the machine-level enable. That enable is 1 when the privilege (`priv_i`: U=0, S=1, M=3) is below M, or when it is M and `mie_i` is 1.
- R3: Lines whose delegation bit is 1 are gated by the supervisor-level enable. That enable is 1 when the privilege is U, or when it is S and `sie_i` is 1. It is 0 in M.
- R4: Within one vector, the delegation bit chooses per line which of the two global enables applies.
- R5: When several gated lines remain, `cause_o` is the index of the least significant one and `take_o` is 1. Both are registered, so they appear one cycle after the inputs and pending state that produced them.
- R6: When no gated line remains, `take_o` is 0 and `cause_o` is 0.
- R7: A pending write with `pend_we_i`=1 sets the register to (old & ~mask) | (value & mask). `pend_old_o` presents the previous contents one cycle after the write and holds them until the next write.
- R8: After each pending write, `irq_req_o` is 1 if any bit of the new pending value is 1, and 0 otherwise.
- R9: A claim request fails (`claim_ok_o`=0, claimed set unchanged) if any requested bit is already claimed. Otherwise it succeeds (`claim_ok_o`=1) and the requested bits join the claimed set. `claim_ack_o` pulses one cycle after each request.
- R10: After reset, the pending register, the claimed set and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_we_i | input | 1 | Pending-register write strobe |
| pend_mask_i | input | 16 | Bits of the pending register to change |
| pend_value_i | input | 16 | New values for the masked bits |
| pend_q_o | output | 16 | Current pending register |
| pend_old_o | output | 16 | Pending contents before the last write |
| irq_req_o | output | 1 | Hart interrupt request |
| enable_i | input | 16 | Per-line interrupt enables |
| deleg_i | input | 16 | Per-line delegation to supervisor level |
| priv_i | input | 2 | Current privilege (0=U, 1=S, 3=M) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 4 | Index of the selected line |
| claim_req_i | input | 1 | Claim request strobe |
| claim_mask_i | input | 16 | Lines to claim |
| claim_ack_o | output | 1 | Claim result valid |
| claim_ok_o | output | 1 | Last claim succeeded |
| claimed_o | output | 16 | Claimed set |

## Verification
A pending write or claim made before a clock edge shows up in `pend_q_o`, `pend_old_o`, `irq_req_o`, `claimed_o`, `claim_ack_o` and `claim_ok_o` right after that edge. The selection uses the pending register as it stood before that edge, so a write reaches `take_o` and `cause_o` only one edge later. The bench drives inputs just after each falling edge. A behavioural model advances at each rising edge, and every output is compared with the model at the following falling edge. This keeps every expected value aligned with the edge at which the design registers it.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned IRQ_LINES = 16;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] value_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] old_o,
  output logic         req_o
);
  logic [N-1:0] pend_q, pend_d, old_q, old_d;
  logic         req_q, req_d;

  always_comb begin
    pend_d = pend_q;
    old_d  = old_q;
    req_d  = req_q;
    if (we_i) begin
      pend_d = (pend_q & ~mask_i) | (value_i & mask_i);
      old_d  = pend_q;
      req_d  = |pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      old_q  <= '0;
      req_q  <= 1'b0;
    end else if (we_i) begin
      pend_q <= pend_d;
      old_q  <= old_d;
      req_q  <= req_d;
    end
  end

  assign pend_o = pend_q;
  assign old_o  = old_q;
  assign req_o  = req_q;

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(pend_o));
  p_old_returned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> old_o == $past(pend_o));
  p_req_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> req_o == (pend_o != '0));
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [N-1:0] mask_i,
  output logic         ack_o,
  output logic         ok_o,
  output logic [N-1:0] claimed_o
);
  logic [N-1:0] own_q, own_d;
  logic         ack_q, ok_q, ok_d;
  logic         clash;

  assign clash = |(own_q & mask_i);

  always_comb begin
    own_d = own_q;
    ok_d  = ok_q;
    if (req_i) begin
      ok_d = !clash;
      if (!clash) own_d = own_q | mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      ok_q  <= 1'b0;
    end else if (req_i) begin
      own_q <= own_d;
      ok_q  <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req_i;
  end

  assign ack_o     = ack_q;
  assign ok_o      = ok_q;
  assign claimed_o = own_q;

  p_fail_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ok_o) |-> claimed_o == $past(claimed_o));
  p_grant_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && ok_o) |-> ($past(mask_i) & ~claimed_o) == '0);
  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(claimed_o) & ~claimed_o) == '0);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  deleg_i,
  input  logic [1:0]    priv_i,
  input  logic          mie_i,
  input  logic          sie_i,
  output logic          hit_o,
  output logic [CW-1:0] idx_o
);
  logic         m_glob, s_glob;
  logic [N-1:0] cand, gated;

  assign m_glob = (priv_i != PRIV_MACH) || mie_i;
  assign s_glob = (priv_i == PRIV_USER) || ((priv_i == PRIV_SUPV) && sie_i);
  assign cand   = pend_i & en_i;

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = cand[g] & (deleg_i[g] ? s_glob : m_glob);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (gated[i]) idx_o = i[CW-1:0];
    end
  end

  assign hit_o = |gated;

  p_priv_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i != PRIV_RSVD);
  p_winner_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> cand[idx_o]);
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (gated & ((N'(1) << idx_o) - N'(1))) == '0);
  p_mach_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == PRIV_MACH && !mie_i) |-> !hit_o);
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
  import irq_sel_pkg::*;
#(
  parameter int unsigned N_IRQ = IRQ_LINES,
  localparam int unsigned CW   = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_we_i,
  input  logic [N_IRQ-1:0] pend_mask_i,
  input  logic [N_IRQ-1:0] pend_value_i,
  output logic [N_IRQ-1:0] pend_q_o,
  output logic [N_IRQ-1:0] pend_old_o,
  output logic             irq_req_o,
  input  logic [N_IRQ-1:0] enable_i,
  input  logic [N_IRQ-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             mie_i,
  input  logic             sie_i,
  output logic             take_o,
  output logic [CW-1:0]    cause_o,
  input  logic             claim_req_i,
  input  logic [N_IRQ-1:0] claim_mask_i,
  output logic             claim_ack_o,
  output logic             claim_ok_o,
  output logic [N_IRQ-1:0] claimed_o
);
  logic [N_IRQ-1:0] pend_cur;
  logic             hit;
  logic [CW-1:0]    idx;
  logic             take_q, take_d;
  logic [CW-1:0]    cause_q, cause_d;

  irq_pend_reg #(.N(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .we_i(pend_we_i), .mask_i(pend_mask_i),
    .value_i(pend_value_i), .pend_o(pend_cur), .old_o(pend_old_o),
    .req_o(irq_req_o)
  );

  irq_prio_sel #(.N(N_IRQ), .CW(CW)) u_sel (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_cur), .en_i(enable_i),
    .deleg_i(deleg_i), .priv_i(priv_i), .mie_i(mie_i), .sie_i(sie_i),
    .hit_o(hit), .idx_o(idx)
  );

  irq_claim_reg #(.N(N_IRQ)) u_claim (
    .clk(clk), .rst_n(rst_n), .req_i(claim_req_i), .mask_i(claim_mask_i),
    .ack_o(claim_ack_o), .ok_o(claim_ok_o), .claimed_o(claimed_o)
  );

  always_comb begin
    take_d  = hit;
    cause_d = hit ? idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      take_q  <= take_d;
      cause_q <= cause_d;
    end
  end

  assign pend_q_o = pend_cur;
  assign take_o   = take_q;
  assign cause_o  = cause_q;

  p_idle_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == '0);
  p_take_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(pend_cur[idx]) || $past(pend_cur[cause_o]));
endmodule

// File: tb/test_irq_select_top.sv
module test_irq_select_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_we = 1'b0;
  logic [15:0] pend_mask = '0, pend_value = '0;
  logic [15:0] enable = '0, deleg = '0;
  logic [1:0]  priv = 2'd3;
  logic        mie = 1'b0, sie = 1'b0;
  logic        claim_req = 1'b0;
  logic [15:0] claim_mask = '0;
  logic [15:0] pend_q, pend_old, claimed;
  logic        irq_req, take, claim_ack, claim_ok;
  logic [3:0]  cause;

  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_select_top i_irq_select_top (
    .clk(clk), .rst_n(rst_n), .pend_we_i(pend_we), .pend_mask_i(pend_mask),
    .pend_value_i(pend_value), .pend_q_o(pend_q), .pend_old_o(pend_old),
    .irq_req_o(irq_req), .enable_i(enable), .deleg_i(deleg), .priv_i(priv),
    .mie_i(mie), .sie_i(sie), .take_o(take), .cause_o(cause),
    .claim_req_i(claim_req), .claim_mask_i(claim_mask),
    .claim_ack_o(claim_ack), .claim_ok_o(claim_ok), .claimed_o(claimed)
  );

  // behavioural reference model
  logic [15:0] m_pend, m_old, m_claimed;
  logic        m_irq, m_take, m_ack, m_ok;
  int          m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_old = 0; m_claimed = 0; m_irq = 0;
      m_take = 0; m_cause = 0; m_ack = 0; m_ok = 0;
    end else begin
      bit mg, sg;
      mg = (priv != 3) || mie;
      sg = (priv == 0) || (priv == 1 && sie);
      m_take = 0; m_cause = 0;
      for (int i = 0; i < 16; i++) begin
        if (!m_take && m_pend[i] && enable[i] && (deleg[i] ? sg : mg)) begin
          m_take = 1; m_cause = i;
        end
      end
      if (pend_we) begin
        m_old  = m_pend;
        m_pend = (m_pend & ~pend_mask) | (pend_value & pend_mask);
        m_irq  = (m_pend != 0);
      end
      m_ack = claim_req;
      if (claim_req) begin
        if ((claim_mask & m_claimed) != 0) m_ok = 0;
        else begin m_ok = 1; m_claimed = m_claimed | claim_mask; end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "take", take, m_take);
    chk(tag, "cause", cause, m_cause);
    chk("R7", "pend", pend_q, m_pend);
    chk("R7", "old", pend_old, m_old);
    chk("R8", "irq_req", irq_req, m_irq);
    chk("R9", "claim_ack", claim_ack, m_ack);
    chk("R9", "claim_ok", claim_ok, m_ok);
    chk("R9", "claimed", claimed, m_claimed);
  endtask

  task automatic wr(input logic [15:0] msk, input logic [15:0] val, input string tag);
    pend_we = 1; pend_mask = msk; pend_value = val;
    cyc(tag);
    pend_we = 0;
    cyc(tag);
  endtask

  task automatic claim(input logic [15:0] msk);
    claim_req = 1; claim_mask = msk;
    cyc("R9");
    claim_req = 0;
    cyc("R9");
  endtask

  task automatic ctx(input logic [1:0] p, input logic m, input logic s, input string tag);
    priv = p; mie = m; sie = s;
    cyc(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state, direct values
    chk("R10", "take", take, 0);
    chk("R10", "pend", pend_q, 0);
    chk("R10", "claimed", claimed, 0);
    chk("R10", "irq_req", irq_req, 0);
    rst_n = 1;
    cyc("R10");
    // R7, R8: masked writes
    wr(16'h00FF, 16'h0F0F, "R7");
    chk("R7", "pend direct", pend_q, 16'h000F);
    wr(16'hFF00, 16'hFFFF, "R7");
    chk("R7", "old direct", pend_old, 16'h000F);
    wr(16'h0000, 16'hFFFF, "R7");
    wr(16'hFFFF, 16'h0000, "R8");
    chk("R8", "irq cleared", irq_req, 0);
    // R1: pending but disabled
    wr(16'h0030, 16'h0030, "R8");
    enable = 16'h0000; priv = 0;
    cyc("R1"); cyc("R1");
    chk("R1", "take disabled", take, 0);
    enable = 16'h0020; cyc("R1"); cyc("R1");
    chk("R1", "cause", cause, 5);
    // R2: machine enable, not delegated
    enable = 16'hFFFF; deleg = 0;
    ctx(3, 0, 1, "R2"); ctx(3, 0, 1, "R2");
    chk("R2", "M masked", take, 0);
    ctx(3, 1, 0, "R2"); ctx(3, 1, 0, "R2");
    chk("R2", "M enabled", take, 1);
    ctx(1, 0, 0, "R2"); ctx(0, 0, 0, "R2");
    // R3: supervisor enable, delegated
    deleg = 16'hFFFF;
    ctx(3, 1, 1, "R3"); ctx(3, 1, 1, "R3");
    chk("R3", "deleg in M", take, 0);
    ctx(1, 0, 0, "R3"); ctx(1, 0, 0, "R3");
    chk("R3", "S masked", take, 0);
    ctx(1, 0, 1, "R3"); ctx(1, 0, 1, "R3");
    chk("R3", "S enabled", take, 1);
    ctx(0, 0, 0, "R3"); ctx(0, 0, 0, "R3");
    // R4: mixed delegation: bit4 delegated, bit5 not
    deleg = 16'h0010;
    ctx(3, 1, 0, "R4"); ctx(3, 1, 0, "R4");
    chk("R4", "M picks 5", cause, 5);
    ctx(1, 0, 0, "R4"); ctx(1, 0, 0, "R4");
    chk("R4", "S picks 5", cause, 5);
    ctx(1, 0, 1, "R4"); ctx(1, 0, 1, "R4");
    chk("R4", "S picks 4", cause, 4);
    // R5: lowest wins
    deleg = 0; ctx(0, 0, 0, "R5");
    wr(16'hFFFF, 16'h8A00, "R5"); cyc("R5");
    chk("R5", "lowest", cause, 9);
    wr(16'hFFFF, 16'h8001, "R5"); cyc("R5");
    chk("R5", "bit0", cause, 0);
    wr(16'hFFFF, 16'h8000, "R5"); cyc("R5");
    chk("R5", "bit15", cause, 15);
    // R6: nothing gated
    wr(16'hFFFF, 16'h0000, "R6"); cyc("R6");
    chk("R6", "none", take, 0);
    chk("R6", "cause0", cause, 0);
    // R9: claims
    claim(16'h0003);
    chk("R9", "ok", claim_ok, 1);
    claim(16'h0006);
    chk("R9", "clash", claim_ok, 0);
    chk("R9", "kept", claimed, 16'h0003);
    claim(16'h00C0);
    chk("R9", "added", claimed, 16'h00C3);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int pr;
      pr = $urandom_range(0, 2);
      priv = (pr == 2) ? 2'd3 : 2'(pr);
      mie = 1'($urandom); sie = 1'($urandom);
      enable = 16'($urandom); deleg = 16'($urandom);
      pend_we = 1'($urandom); pend_mask = 16'($urandom); pend_value = 16'($urandom);
      claim_req = ($urandom_range(0, 7) == 0);
      claim_mask = 16'(1) << $urandom_range(0, 15);
      cyc("R5");
    end
    pend_we = 0; claim_req = 0;
    cyc("R5");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule